// File: doc/BRIEF.md
# Per-Channel Sample Formatter and Decimator

This block sits on one acquisition channel. It takes samples from a bank of input channels, or from a built-in counter, and picks one source with a small select code. Each accepted sample has its sign extended upward from a programmable bit position, or has the bits above that position cleared. The stream is then slowed by a programmable divisor, either by keeping one sample in every group or by averaging the samples of a power-of-two window. In half-width mode the results are cut to 16 bits, and two of them share one 32-bit output word.

All behaviour is set by three inputs that the user holds steady while data flows: the source select, an 8-bit format byte and a 16-bit rate divisor. The input side and the output side are both a plain valid/data pair with no back-pressure. Each output word appears one clock after the input sample that completes it.

Top module: `sample_fmt_decim`

## Requirements
- R1: Select code 0 disables the channel. No output word is produced, and the decimation phase, the partial average and any held half word are cleared, so the next enabled sample starts a fresh group.
- R2: Select code 1 produces a test counter. It supplies one sample every clock, starts at 0 after reset and increments by 1 on each clock in which it is selected.
- R3: Select code 2+n takes input channel n (n from 0 to 29). Only that channel's valid bit produces samples, and activity on other channels has no effect.
- R4: When format bit 6 is 1 (signed), every sample bit above position P = format bits 4..0 is replaced by sample bit P.
- R5: When format bit 6 is 0 (unsigned), every sample bit above position P is cleared, and bits P and below are passed unchanged.
- R6: With format bit 7 = 0, a divisor D passes the first sample of each group of D accepted samples and drops the rest. D = 0 acts as D = 1, which passes every sample.
- R7: With format bit 7 = 1, the window is 2^k, where k is the index of the highest set bit of D (D = 0 acts as 1). One result is produced per window, equal to the window sum shifted right by k, arithmetically when signed.
- R8: With format bit 5 = 1, each result is cut to its low 16 bits. Two consecutive results form one output word, with the first in bits 15..0 and the second in bits 31..16, and no word is produced after the first of a pair.
- R9: An output word is valid exactly one clock after the edge that accepts the sample completing it. out_valid and out_data are 0 after reset.
- R10: The average does not overflow at the largest window (2^15) even when every sample is the full-scale value 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 30 | Per-channel sample valid |
| in_data | input | 960 | Channel samples, channel n in bits 32n+31..32n |
| sel | input | 5 | Source select code |
| fmt | input | 8 | Format byte: sign position, half-width, signed, averaging |
| rate_div | input | 16 | Decimation divisor |
| out_valid | output | 1 | Output word valid |
| out_data | output | 32 | Output word |

## Verification
Two functions can finish on the same clock edge: the last sample of an averaging window and the second half of a packed 16-bit pair. The bench sets half-width averaging with a window of two and feeds four samples. This makes the second window complete at the same edge as the pair. It checks that no word appears earlier and that the single word carries both averages, each in its own half.

// File: rtl/sample_fmt_decim.sv
module sample_fmt_decim #(
  parameter int NCH  = 30,
  parameter int DW   = 32,
  parameter int SELW = 5,
  parameter int DIVW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    in_valid,
  input  logic [NCH*DW-1:0] in_data,
  input  logic [SELW-1:0]   sel,
  input  logic [7:0]        fmt,
  input  logic [DIVW-1:0]   rate_div,
  output logic              out_valid,
  output logic [DW-1:0]     out_data
);
  localparam int HW   = DW / 2;
  localparam int PW   = $clog2(DW);
  localparam int KW   = $clog2(DIVW);
  localparam int ACCW = DW + DIVW;

  logic [DW-1:0]   test_cnt;
  logic            src_valid;
  logic [DW-1:0]   src_data;
  logic [DW-1:0]   fmt_data;
  logic [ACCW-1:0] samp_ext, acc, sum, avg_full;
  logic [DIVW-1:0] cnt, div_eff, limit;
  logic [KW-1:0]   k;
  logic [DW-1:0]   result;
  logic            half_q;
  logic [HW-1:0]   low_q;

  wire [PW-1:0] pos       = fmt[PW-1:0];
  wire          half_mode = fmt[5];
  wire          is_signed = fmt[6];
  wire          avg_en    = fmt[7];
  wire          disabled  = (sel == '0);

  always_comb begin
    src_valid = 1'b0;
    src_data  = '0;
    if (sel == SELW'(1)) begin
      src_valid = 1'b1;
      src_data  = test_cnt;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (sel == SELW'(i + 2)) begin
          src_valid = in_valid[i];
          src_data  = in_data[i*DW +: DW];
        end
      end
    end
  end

  always_comb begin
    for (int j = 0; j < DW; j++)
      fmt_data[j] = (j <= int'(pos)) ? src_data[j] : (is_signed & src_data[pos]);
  end

  assign samp_ext = half_mode
    ? {{(ACCW-HW){is_signed & fmt_data[HW-1]}}, fmt_data[HW-1:0]}
    : {{(ACCW-DW){is_signed & fmt_data[DW-1]}}, fmt_data};

  assign div_eff = (rate_div == '0) ? DIVW'(1) : rate_div;

  always_comb begin
    k = '0;
    for (int i = 0; i < DIVW; i++)
      if (div_eff[i]) k = KW'(i);
  end

  assign limit    = avg_en ? ((DIVW'(1) << k) - DIVW'(1)) : (div_eff - DIVW'(1));
  wire   last     = (cnt >= limit);
  wire   emit     = avg_en ? last : (cnt == '0);
  assign sum      = acc + samp_ext;
  assign avg_full = is_signed ? ACCW'($signed(sum) >>> k) : (sum >> k);
  assign result   = avg_en ? avg_full[DW-1:0] : fmt_data;

  always_ff @(posedge clk) begin
    if (!rst_n)
      test_cnt <= '0;
    else if (sel == SELW'(1))
      test_cnt <= test_cnt + DW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      acc       <= '0;
      half_q    <= 1'b0;
      low_q     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (disabled) begin
        cnt    <= '0;
        acc    <= '0;
        half_q <= 1'b0;
      end else if (src_valid) begin
        cnt <= last ? '0 : cnt + DIVW'(1);
        acc <= (avg_en && !last) ? sum : '0;
        if (emit) begin
          if (!half_mode) begin
            out_valid <= 1'b1;
            out_data  <= result;
            half_q    <= 1'b0;
          end else if (!half_q) begin
            low_q  <= result[HW-1:0];
            half_q <= 1'b1;
          end else begin
            out_valid <= 1'b1;
            out_data  <= {result[HW-1:0], low_q};
            half_q    <= 1'b0;
          end
        end
      end
    end
  end

  assert_disabled_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    disabled |=> !out_valid);

  assert_test_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SELW'(1)) |=> (test_cnt == $past(test_cnt) + DW'(1)));

  assert_output_from_sample_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(src_valid));

  assert_pair_complete_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !half_q);
endmodule

// File: tb/test_sample_fmt_decim.sv
module test_sample_fmt_decim;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [29:0]   in_valid = '0;
  logic [959:0]  in_data = '0;
  logic [4:0]    sel = '0;
  logic [7:0]    fmt = '0;
  logic [15:0]   rate_div = '0;
  logic          out_valid;
  logic [31:0]   out_data;
  int            n_tests = 0;
  int            n_fail = 0;
  bit            done = 1'b0;

  always #10 clk = ~clk;

  sample_fmt_decim i_sample_fmt_decim (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .sel(sel), .fmt(fmt), .rate_div(rate_div),
    .out_valid(out_valid), .out_data(out_data));

  // fmt, input sample, expected output (32-bit mode, no decimation)
  localparam logic [71:0] VEC [10] = '{
    {8'h1F, 32'h89ABCDEF, 32'h89ABCDEF},
    {8'h5F, 32'h89ABCDEF, 32'h89ABCDEF},
    {8'h4F, 32'h00008000, 32'hFFFF8000},
    {8'h4F, 32'hFFFF7FFF, 32'h00007FFF},
    {8'h0F, 32'hABCD1234, 32'h00001234},
    {8'h47, 32'h00000080, 32'hFFFFFF80},
    {8'h40, 32'h00000001, 32'hFFFFFFFF},
    {8'h00, 32'hFFFFFFFE, 32'h00000000},
    {8'h4B, 32'h12345678, 32'h00000678},
    {8'h0B, 32'hFFFFF9AB, 32'h000009AB}
  };

  task automatic tick(input int ch, input logic v, input logic [31:0] d);
    in_valid = '0;
    in_data  = '0;
    if (v) begin
      in_valid[ch] = 1'b1;
      in_data[ch*32 +: 32] = d;
    end
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic clear_ch();
    sel = 5'd0;
    tick(0, 1'b0, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog got timeout exp completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int early;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R9 reset valid", 32'(out_valid), 32'd0);
    chk("R9 reset data", out_data, 32'd0);

    // R2 test counter right after reset
    sel = 5'd1; fmt = 8'h1F; rate_div = 16'd1;
    for (int i = 0; i < 3; i++) begin
      tick(0, 1'b0, 32'h0);
      chk("R2 counter valid", 32'(out_valid), 32'd1);
      chk("R2 counter value", out_data, 32'(i));
    end
    clear_ch();

    // R4 R5 R9 formatting table on channel 3
    sel = 5'd5;
    for (int i = 0; i < 10; i++) begin
      fmt = VEC[i][71:64];
      tick(3, 1'b1, VEC[i][63:32]);
      chk("R4/R5 fmt valid", 32'(out_valid), 32'd1);
      chk((VEC[i][70]) ? "R4 signed" : "R5 unsigned", out_data, VEC[i][31:0]);
    end
    clear_ch();

    // R3 channel selection
    fmt = 8'h1F; rate_div = 16'd1; sel = 5'd2;
    tick(1, 1'b1, 32'h55);
    chk("R3 other channel ignored", 32'(out_valid), 32'd0);
    tick(0, 1'b1, 32'h66);
    chk("R3 ch0 data", out_data, 32'h66);
    sel = 5'd31;
    tick(29, 1'b1, 32'h77);
    chk("R3 ch29 valid", 32'(out_valid), 32'd1);
    chk("R3 ch29 data", out_data, 32'h77);

    // R1 disabled
    sel = 5'd0;
    tick(0, 1'b1, 32'h99);
    chk("R1 disabled quiet", 32'(out_valid), 32'd0);
    sel = 5'd2; rate_div = 16'd2;
    tick(0, 1'b1, 32'h10);
    chk("R1 first sample", out_data, 32'h10);
    clear_ch();
    sel = 5'd2;
    tick(0, 1'b1, 32'h11);
    chk("R1 phase cleared", 32'(out_valid), 32'd1);
    clear_ch();
    sel = 5'd2; fmt = 8'h2F; rate_div = 16'd1;
    tick(0, 1'b1, 32'hDEAD);
    clear_ch();
    sel = 5'd2;
    tick(0, 1'b1, 32'h0001);
    chk("R1 half cleared no word", 32'(out_valid), 32'd0);
    tick(0, 1'b1, 32'h0002);
    chk("R1 half cleared pair", out_data, 32'h00020001);
    clear_ch();

    // R6 subsampling
    sel = 5'd2; fmt = 8'h1F; rate_div = 16'd3;
    for (int i = 0; i < 7; i++) begin
      tick(0, 1'b1, 32'(10 + i));
      chk("R6 subsample valid", 32'(out_valid), (i % 3 == 0) ? 32'd1 : 32'd0);
      if (i % 3 == 0) chk("R6 subsample data", out_data, 32'(10 + i));
      if (i == 1) begin
        tick(0, 1'b0, 32'h0);
        chk("R6 idle no output", 32'(out_valid), 32'd0);
      end
    end
    clear_ch();
    sel = 5'd2; rate_div = 16'd0;
    for (int i = 0; i < 3; i++) begin
      tick(0, 1'b1, 32'(40 + i));
      chk("R6 divisor zero", out_data, 32'(40 + i));
    end
    clear_ch();

    // R7 averaging
    sel = 5'd2; fmt = 8'h9F; rate_div = 16'd4;
    tick(0, 1'b1, 32'd1); tick(0, 1'b1, 32'd2); tick(0, 1'b1, 32'd3);
    chk("R7 no early result", 32'(out_valid), 32'd0);
    tick(0, 1'b1, 32'd6);
    chk("R7 mean of four", out_data, 32'd3);
    clear_ch();
    sel = 5'd2; rate_div = 16'd6;
    tick(0, 1'b1, 32'd4); tick(0, 1'b1, 32'd4); tick(0, 1'b1, 32'd4);
    tick(0, 1'b1, 32'd8);
    chk("R7 divisor six uses four", out_data, 32'd5);
    clear_ch();
    sel = 5'd2; fmt = 8'hDF; rate_div = 16'd2;
    tick(0, 1'b1, 32'hFFFFFFFF);
    tick(0, 1'b1, 32'hFFFFFFFE);
    chk("R7 signed mean", out_data, 32'hFFFFFFFE);
    clear_ch();

    // R8 packing, and averaging completing with a pair
    sel = 5'd2; fmt = 8'h2F; rate_div = 16'd1;
    tick(0, 1'b1, 32'h1111AAAA);
    chk("R8 first half held", 32'(out_valid), 32'd0);
    tick(0, 1'b1, 32'h2222BBBB);
    chk("R8 packed word", out_data, 32'hBBBBAAAA);
    clear_ch();
    sel = 5'd2; fmt = 8'hAF; rate_div = 16'd2;
    tick(0, 1'b1, 32'h2); tick(0, 1'b1, 32'h4); tick(0, 1'b1, 32'h10);
    chk("R8 avg pair not early", 32'(out_valid), 32'd0);
    tick(0, 1'b1, 32'h20);
    chk("R8 avg pair word", out_data, 32'h00180003);
    clear_ch();

    // R10 largest window, full scale
    sel = 5'd2; fmt = 8'h9F; rate_div = 16'h8000;
    early = 0;
    for (int i = 0; i < 32768; i++) begin
      tick(0, 1'b1, 32'hFFFFFFFF);
      if (i < 32767 && out_valid) early++;
    end
    chk("R10 no early output", 32'(early), 32'd0);
    chk("R10 full scale mean", out_data, 32'hFFFFFFFF);
    chk("R10 valid", 32'(out_valid), 32'd1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule